// File: doc/BRIEF.md
# MDIO Management Register Controller

This block is a memory-mapped MDIO master for reaching PHY management registers over a two-wire serial bus. Software first sets up the transfer in two registers. The address register holds the target PHY, the register number and the direction. The write-data register holds the value to write. Software then sets the start flag in the control register. The controller sends one Clause 22 management frame on MDC and a tristate MDIO line. The same flag reads back as busy until the frame has finished.

MDC comes from the system clock divided by an even parameter `CLK_DIV`, and it stays low while the bus is idle. The controller drives MDIO, which changes only on falling MDC edges. On a read, the controller stops driving MDIO for the end of the turnaround and for the whole data field. It samples the PHY's bits on rising MDC edges, and the 16-bit result goes to the read-data register. A frame can start only if the enable flag in the same control write is set. The enable flag can be read back, so software can check whether management access is available.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset all registers read as zero, MDC is low and MDIO is released (`mdio_oe` low).
- R2: Register map (byte offsets). 0x7E4 is the address register: bits 4:0 register number, bits 9:5 PHY address, bit 10 direction (1 = read, 0 = write). 0x7E8 is the write data in bits 15:0. 0x7EC is the read result in bits 15:0. 0x7F0 is the control register: bit 0 is start/busy, bit 3 is enable. Unused bits and unmapped offsets read as zero.
- R3: A control write with bit 0 and bit 3 both set, made while idle, starts a frame. Bit 0 reads 1 from the next cycle until the frame ends, then reads 0. A frame lasts exactly 64 MDC periods.
- R4: A control write whose bit 3 is 0 starts no frame: MDC stays low and the busy flag stays 0.
- R5: The frame on the line is, in order: 32 ones, start 01, opcode (10 read, 01 write), PHY address, register number, two turnaround bits, and 16 data bits. Every field is sent MSB first. On a write the turnaround is 10.
- R6: MDC has a period of `CLK_DIV` system clocks, with a high time of `CLK_DIV/2`.
- R7: MDIO changes only at a falling MDC edge. It never changes while MDC is high.
- R8: On a read, the controller drives the first turnaround bit as 1. It releases MDIO from bit 47 (the second turnaround bit) through bit 63. The 16 bits sampled on the rising MDC edges of bits 48 to 63 become the read-data register value.
- R9: A read from a PHY address where nothing answers returns 0xFFFF, because the idle line is pulled up.
- R10: While a frame is running, a control write does not start another frame. Writes to the address or write-data registers update their readback values but do not change the frame in progress.
- R11: The enable bit can be written and read back on its own, without starting a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset for writes and reads |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pad |

## Verification
The embedded assertions check several rules on every clock:
- MDC stays low and MDIO stays released whenever the controller is idle.
- MDIO holds steady while MDC is high.
- A control write without the enable bit never raises busy.
- Every frame begins with a driven one.
- The controller never drives MDIO in the released part of a read.
- Busy holds until the last bit period has ended.

The bench runs an MDIO PHY model and checks what only whole transfers can show:
- the exact 64-bit line pattern;
- the MDC period and the edge count;
- that a register written through MDIO reads back through MDIO;
- the 0xFFFF result from an empty PHY address;
- that a frame in progress is immune to register writes.

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
  parameter int ADDR_W  = 13,
  parameter int CLK_DIV = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);

  localparam int CW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] HI_AT  = CW'(CLK_DIV/2 - 1);
  localparam logic [CW-1:0] END_AT = CW'(CLK_DIV - 1);
  localparam logic [ADDR_W-1:0] OFS_ADR = ADDR_W'(12'h7E4);
  localparam logic [ADDR_W-1:0] OFS_WD  = ADDR_W'(12'h7E8);
  localparam logic [ADDR_W-1:0] OFS_RD  = ADDR_W'(12'h7EC);
  localparam logic [ADDR_W-1:0] OFS_CTL = ADDR_W'(12'h7F0);

  logic [4:0]    reg_num, phy_num;
  logic          op_rd, en, busy, frame_rd;
  logic [15:0]   wr_val, rd_val, rx_sh;
  logic [CW-1:0] div_cnt;
  logic [5:0]    bit_idx;
  logic [63:0]   tx_sh;

  wire ctl_wr   = wr_en && addr == OFS_CTL;
  wire go       = ctl_wr && !busy && wdata[0] && wdata[3];
  wire rise_now = busy && div_cnt == HI_AT;
  wire bit_end  = busy && div_cnt == END_AT;
  wire last_bit = bit_idx == 6'd63;
  wire [63:0] frame = {32'hFFFF_FFFF, 2'b01, op_rd ? 2'b10 : 2'b01,
                       phy_num, reg_num, 2'b10, op_rd ? 16'h0000 : wr_val};

  assign mdio_o  = busy & tx_sh[63];
  assign mdio_oe = busy & ~(frame_rd & (bit_idx >= 6'd47));

  always_comb begin
    rdata = 32'h0;
    if (addr == OFS_ADR) rdata = {21'h0, op_rd, phy_num, reg_num};
    else if (addr == OFS_WD) rdata = {16'h0, wr_val};
    else if (addr == OFS_RD) rdata = {16'h0, rd_val};
    else if (addr == OFS_CTL) rdata = {28'h0, en, 2'b00, busy};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_num <= '0;
      phy_num <= '0;
      op_rd   <= 1'b0;
      wr_val  <= '0;
      en      <= 1'b0;
    end else if (wr_en) begin
      if (addr == OFS_ADR) {op_rd, phy_num, reg_num} <= wdata[10:0];
      if (addr == OFS_WD)  wr_val <= wdata[15:0];
      if (addr == OFS_CTL) en <= wdata[3];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      frame_rd <= 1'b0;
      mdc      <= 1'b0;
      div_cnt  <= '0;
      bit_idx  <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      rd_val   <= '0;
    end else if (go) begin
      busy     <= 1'b1;
      frame_rd <= op_rd;
      mdc      <= 1'b0;
      div_cnt  <= '0;
      bit_idx  <= '0;
      tx_sh    <= frame;
    end else if (busy) begin
      div_cnt <= bit_end ? '0 : div_cnt + 1'b1;
      if (rise_now) begin
        mdc <= 1'b1;
        if (frame_rd && bit_idx >= 6'd48) rx_sh <= {rx_sh[14:0], mdio_i};
      end
      if (bit_end) begin
        mdc <= 1'b0;
        if (last_bit) begin
          busy <= 1'b0;
          if (frame_rd) rd_val <= rx_sh;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          tx_sh   <= {tx_sh[62:0], 1'b0};
        end
      end
    end
  end

  a_r6_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc && !mdio_oe);

  a_r7_mdio_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  a_r4_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !wdata[3] && !busy) |=> !busy);

  a_r5_preamble_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mdio_oe && mdio_o);

  a_r8_no_drive_in_read_data: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mdc && frame_rd && bit_idx >= 6'd48) |-> !mdio_oe);

  a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(bit_end && last_bit)) |=> busy);

endmodule

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb;
  localparam int ADDR_W = 13;
  localparam int DIV = 8;
  localparam logic [4:0] PHY = 5'd9;
  localparam logic [12:0] A_ADR = 13'h7E4, A_WD = 13'h7E8, A_RD = 13'h7EC, A_CTL = 13'h7F0;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic mdc, mdio_o, mdio_oe, mdio_i;
  logic phy_drv = 1'b0, phy_val = 1'b0;

  int checks = 0, errors = 0;
  int cnt = 0, rises = 0;
  longint cyc = 0, last_rise = 0, period = 0;
  logic [63:0] cap = '0;
  logic [15:0] phy_mem [32];
  logic [15:0] shadow [32];

  always #2 clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);

  mdio_mgmt_ctrl #(.ADDR_W(ADDR_W), .CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge mdc) begin
    if (cnt < 64) cap[63-cnt] = mdio_i;
    cnt = cnt + 1;
    rises = rises + 1;
    period = cyc - last_rise;
    last_rise = cyc;
    if (cnt == 64 && cap[29:28] == 2'b01 && cap[27:23] == PHY)
      phy_mem[cap[22:18]] = cap[15:0];
  end

  always @(negedge mdc) begin
    if (cnt >= 47 && cnt < 64 && cap[29:28] == 2'b10 && cap[27:23] == PHY) begin
      phy_drv = 1'b1;
      phy_val = (cnt == 47) ? 1'b0 : phy_mem[cap[22:18]][15-(cnt-48)];
    end else phy_drv = 1'b0;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n && mdio_oe && phy_drv) begin
    checks++; errors++;
    $display("FAIL R8: contention actual 1 expected 0");
  end

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk); wr_en = 1'b0; addr = a; #1 d = rdata;
  endtask

  function automatic logic [63:0] exp_frame(bit r, logic [4:0] p, logic [4:0] g, logic [15:0] d, bit ta1);
    return {32'hFFFF_FFFF, 2'b01, r ? 2'b10 : 2'b01, p, g, 1'b1, ta1, d};
  endfunction

  task automatic wait_idle();
    logic [31:0] v;
    int guard = 0;
    do begin rd(A_CTL, v); guard++; end while (v[0] && guard < 2000);
  endtask

  task automatic txn(input bit r, input logic [4:0] p, input logic [4:0] g, input logic [15:0] d);
    logic [31:0] v;
    logic [15:0] exp_d;
    bit present;
    present = (p == PHY);
    wr(A_ADR, {21'h0, r, p, g});
    wr(A_WD, {16'h0, d});
    cnt = 0; rises = 0; cap = '0;
    wr(A_CTL, 32'h9);
    rd(A_CTL, v);
    check(v[0] == 1'b1, "R3 busy after start", v, 64'h1);
    wait_idle();
    check(rises == 64, "R3 mdc edges per frame", rises, 64);
    check(period == DIV, "R6 mdc period", period, DIV);
    if (r) begin
      exp_d = present ? shadow[g] : 16'hFFFF;
      check(cap == exp_frame(1'b1, p, g, exp_d, !present), "R5 read frame", cap, exp_frame(1'b1, p, g, exp_d, !present));
      rd(A_RD, v);
      check(v == {16'h0, exp_d}, present ? "R8 R7 read data" : "R9 absent phy", v, exp_d);
    end else begin
      check(cap == exp_frame(1'b0, p, g, d, 1'b0), "R5 write frame", cap, exp_frame(1'b0, p, g, d, 1'b0));
      if (present) shadow[g] = d;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) begin phy_mem[i] = 16'h1000 + 16'(i); shadow[i] = 16'h1000 + 16'(i); end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    rd(A_ADR, v); check(v == 0, "R1 addr reg reset", v, 0);
    rd(A_CTL, v); check(v == 0, "R1 ctrl reset", v, 0);
    check(mdc == 0 && mdio_oe == 0, "R1 pins idle", {mdc, mdio_oe}, 0);

    wr(A_ADR, 32'hFFFF_F5A3);
    rd(A_ADR, v); check(v == 32'h5A3, "R2 addr fields", v, 32'h5A3);
    wr(A_WD, 32'hABCD_1234);
    rd(A_WD, v); check(v == 32'h1234, "R2 wdata", v, 32'h1234);
    rd(13'h000, v); check(v == 0, "R2 unmapped", v, 0);

    wr(A_CTL, 32'h8);
    rd(A_CTL, v); check(v == 32'h8, "R11 enable set", v, 8);
    wr(A_CTL, 32'h0);
    rd(A_CTL, v); check(v == 0, "R11 enable clear", v, 0);

    rises = 0;
    wr(A_CTL, 32'h1);
    repeat (3 * DIV) @(negedge clk);
    rd(A_CTL, v);
    check(rises == 0 && v[0] == 0, "R4 start without enable", {rises[31:0], v}, 0);

    txn(1'b0, PHY, 5'd4, 16'hBEEF);
    txn(1'b1, PHY, 5'd4, 16'h0);
    txn(1'b1, 5'd3, 5'd1, 16'h0);
    txn(1'b0, PHY, 5'd0, 16'h8001);
    txn(1'b1, PHY, 5'd0, 16'h0);

    wr(A_ADR, {21'h0, 1'b0, PHY, 5'd7});
    wr(A_WD, 32'h0000_C3C3);
    cnt = 0; rises = 0;
    wr(A_CTL, 32'h9);
    repeat (10 * DIV) @(negedge clk);
    wr(A_ADR, {21'h0, 1'b1, 5'd2, 5'd12});
    wr(A_WD, 32'h0000_1111);
    wr(A_CTL, 32'h9);
    wait_idle();
    check(rises == 64, "R10 single frame", rises, 64);
    check(cap == exp_frame(1'b0, PHY, 5'd7, 16'hC3C3, 1'b0), "R10 frame unchanged", cap, exp_frame(1'b0, PHY, 5'd7, 16'hC3C3, 1'b0));
    shadow[7] = 16'hC3C3;
    rd(A_ADR, v); check(v == {21'h0, 1'b1, 5'd2, 5'd12}, "R10 addr reg updated", v, {21'h0, 1'b1, 5'd2, 5'd12});
    rises = 0;
    repeat (3 * DIV) @(negedge clk);
    check(rises == 0, "R10 no queued start", rises, 0);
    txn(1'b1, PHY, 5'd7, 16'h0);

    for (int k = 0; k < 12; k++) begin
      bit r;
      logic [4:0] p, g;
      logic [15:0] d;
      r = 1'($urandom_range(0, 1));
      p = ($urandom_range(0, 3) == 0) ? 5'($urandom_range(0, 31)) : PHY;
      g = 5'($urandom_range(0, 31));
      d = 16'($urandom);
      txn(r, p, g, d);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule